// File: doc/BRIEF.md
# Register Renamer with Branch Checkpoints

This block gives out-of-order issue logic fresh physical register names. Each issued instruction presents up to two architectural source registers and an optional architectural destination. The sources are looked up in a map table and come back as physical register numbers. A writing instruction takes the next physical register from a circular free list, and the map entry for its destination is overwritten with that register. The physical register it displaces is returned so the reorder buffer can keep it until commit. At commit the reorder buffer hands that displaced register back, and it is appended to the free list.

Every issued branch saves a snapshot of the map table and the free-list read pointer. Branches resolve in program order. A correct resolution drops the oldest snapshot. A mispredict restores the map table and the free-list read pointer from the oldest snapshot in one cycle and discards every outstanding snapshot. Any register pushed by commit keeps its place at the free-list tail. The reset input is asynchronous and active low, and the surrounding chip must release it synchronously.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers NUM_ARCH to NUM_PHYS-1, in ascending order.
- R2: Source lookups use the map as it stood before the same instruction's destination update. A source equal to the destination returns the old mapping.
- R3: An issue with `iss_dst_we_i`=1 returns the free-list head as `dst_phys_o` and the old mapping as `prev_phys_o`, and later lookups of that destination return `dst_phys_o`.
- R4: When the free list is empty, `iss_ready_o` is 0 for a writing instruction. It stays 1 for a non-writing instruction.
- R5: A commit with `cmt_valid_i`=1 appends `cmt_prev_phys_i` to the free-list tail. It is handed out again only after every register already on the list.
- R6: An issued branch (`iss_branch_i`=1) saves the map as updated by that instruction, together with the free-list read pointer. While NUM_CKPT snapshots are outstanding, `iss_ready_o` is 0 for a branch.
- R7: A cycle with `br_resolve_i`=1 and `br_mispredict_i`=1 holds `iss_ready_o` at 0. The next cycle sees the map and the free-list read pointer of the oldest snapshot, and no snapshot is outstanding.
- R8: A cycle with `br_resolve_i`=1 and `br_mispredict_i`=0 releases the oldest snapshot and leaves the map unchanged.
- R9: A commit in the same cycle as a mispredict still appends its register to the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | An instruction is presented for renaming |
| iss_dst_we_i | input | 1 | The instruction writes a destination register |
| iss_branch_i | input | 1 | The instruction is a branch and needs a snapshot |
| iss_dst_i | input | AW | Architectural destination |
| iss_src_a_i | input | AW | Architectural source A |
| iss_src_b_i | input | AW | Architectural source B |
| iss_ready_o | output | 1 | The instruction is accepted this cycle when valid |
| src_a_phys_o | output | PW | Physical register for source A |
| src_b_phys_o | output | PW | Physical register for source B |
| dst_phys_o | output | PW | Newly allocated physical destination |
| prev_phys_o | output | PW | Displaced mapping of the destination |
| cmt_valid_i | input | 1 | Commit returns a displaced register |
| cmt_prev_phys_i | input | PW | Register freed by the commit |
| br_resolve_i | input | 1 | The oldest outstanding branch resolves |
| br_mispredict_i | input | 1 | With resolve: the branch was mispredicted |

## Verification
The bench covers back-to-back writes to one architectural register and a source that names its own destination. A renamer that updated the map before the lookup would return the new register for that source. It then allocates after a checkpoint, mispredicts while a commit is in flight, and checks that the same physical registers are handed out again. A wrong read pointer restore, or a restore that also rewound the tail, would give a different number or lose the committed register. It drains the free list, fills the checkpoint queue, and checks that recycled registers come back in FIFO order behind the original free ones.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    CK_HOLD    = 2'd0,
    CK_TAKE    = 2'd1,
    CK_RELEASE = 2'd2,
    CK_BOTH    = 2'd3
  } ck_op_e;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int IW    = $clog2(DEPTH),
  localparam int PTRW  = IW + 1,
  localparam int PW    = $clog2(NUM_PHYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop_i,
  input  logic            push_i,
  input  logic [PW-1:0]   push_phys_i,
  input  logic            restore_i,
  input  logic [PTRW-1:0] restore_head_i,
  output logic [PW-1:0]   head_phys_o,
  output logic [PTRW-1:0] head_ptr_o,
  output logic            empty_o
);
  logic [PW-1:0]   mem_q [DEPTH];
  logic [PW-1:0]   mem_d [DEPTH];
  logic [PTRW-1:0] head_q, head_d, tail_q, tail_d;
  logic [PTRW-1:0] count;

  assign count       = tail_q - head_q;
  assign empty_o     = (count == '0);
  assign head_phys_o = mem_q[head_q[IW-1:0]];
  assign head_ptr_o  = head_q;

  always_comb begin
    mem_d  = mem_q;
    tail_d = tail_q;
    if (push_i) begin
      mem_d[tail_q[IW-1:0]] = push_phys_i;
      tail_d = tail_q + PTRW'(1);
    end
    if (restore_i)  head_d = restore_head_i;
    else if (pop_i) head_d = head_q + PTRW'(1);
    else            head_d = head_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= {1'b1, {IW{1'b0}}};
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= PW'(NUM_ARCH + i);
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      mem_q  <= mem_d;
    end
  end

  assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (count < PTRW'(DEPTH)));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [AW-1:0]                rd_a_i,
  input  logic [AW-1:0]                rd_b_i,
  input  logic [AW-1:0]                rd_d_i,
  output logic [PW-1:0]                rd_a_o,
  output logic [PW-1:0]                rd_b_o,
  output logic [PW-1:0]                rd_d_o,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                wr_idx_i,
  input  logic [PW-1:0]                wr_phys_i,
  input  logic                         restore_i,
  input  logic [NUM_ARCH-1:0][PW-1:0]  restore_map_i,
  output logic [NUM_ARCH-1:0][PW-1:0]  map_cur_o,
  output logic [NUM_ARCH-1:0][PW-1:0]  map_next_o
);
  logic [NUM_ARCH-1:0][PW-1:0] map_q, map_d;

  assign rd_a_o     = map_q[rd_a_i];
  assign rd_b_o     = map_q[rd_b_i];
  assign rd_d_o     = map_q[rd_d_i];
  assign map_cur_o  = map_q;
  assign map_next_o = map_d;

  always_comb begin
    map_d = map_q;
    if (restore_i)    map_d = restore_map_i;
    else if (wr_en_i) map_d[wr_idx_i] = wr_phys_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else begin
      map_q <= map_d;
    end
  end

  assert_one_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(restore_i && wr_en_i));
endmodule

// File: rtl/rn_ckpt_queue.sv
module rn_ckpt_queue #(
  parameter int NUM_CKPT = 2,
  parameter int W        = 36,
  localparam int CW   = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
  localparam int CNTW = $clog2(NUM_CKPT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_i,
  input  logic [W-1:0] payload_i,
  input  logic         release_i,
  input  logic         flush_i,
  output logic [W-1:0] oldest_o,
  output logic         full_o
);
  import rn_pkg::*;

  logic [W-1:0]    mem_q [NUM_CKPT];
  logic [W-1:0]    mem_d [NUM_CKPT];
  logic [CW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            empty;
  ck_op_e          op;

  function automatic logic [CW-1:0] wrap_inc(input logic [CW-1:0] p);
    return (p == CW'(NUM_CKPT - 1)) ? '0 : p + CW'(1);
  endfunction

  assign full_o   = (cnt_q == CNTW'(NUM_CKPT));
  assign empty    = (cnt_q == '0);
  assign oldest_o = mem_q[rd_q];
  assign op       = ck_op_e'({release_i, take_i});

  always_comb begin
    mem_d = mem_q;
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      unique case (op)
        CK_TAKE: begin
          mem_d[wr_q] = payload_i;
          wr_d  = wrap_inc(wr_q);
          cnt_d = cnt_q + CNTW'(1);
        end
        CK_RELEASE: begin
          rd_d  = wrap_inc(rd_q);
          cnt_d = cnt_q - CNTW'(1);
        end
        CK_BOTH: begin
          mem_d[wr_q] = payload_i;
          wr_d = wrap_inc(wr_q);
          rd_d = wrap_inc(rd_q);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < NUM_CKPT; i++) mem_q[i] <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      mem_q <= mem_d;
    end
  end

  assert_take_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> !full_o);
  assert_resolve_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i || flush_i) |-> !empty);
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> empty);
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int NUM_CKPT = 2,
  localparam int AW   = $clog2(NUM_ARCH),
  localparam int PW   = $clog2(NUM_PHYS),
  localparam int PTRW = $clog2(NUM_PHYS - NUM_ARCH) + 1,
  localparam int CKW  = NUM_ARCH * PW + PTRW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid_i,
  input  logic          iss_dst_we_i,
  input  logic          iss_branch_i,
  input  logic [AW-1:0] iss_dst_i,
  input  logic [AW-1:0] iss_src_a_i,
  input  logic [AW-1:0] iss_src_b_i,
  output logic          iss_ready_o,
  output logic [PW-1:0] src_a_phys_o,
  output logic [PW-1:0] src_b_phys_o,
  output logic [PW-1:0] dst_phys_o,
  output logic [PW-1:0] prev_phys_o,
  input  logic          cmt_valid_i,
  input  logic [PW-1:0] cmt_prev_phys_i,
  input  logic          br_resolve_i,
  input  logic          br_mispredict_i
);
  logic                        fire, alloc, take, restore, release_ck;
  logic                        fl_empty, ck_full;
  logic [PW-1:0]               fl_head_phys;
  logic [PTRW-1:0]             fl_head_ptr, head_after;
  logic [NUM_ARCH-1:0][PW-1:0] map_cur, map_next, ck_map;
  logic [CKW-1:0]              ck_oldest, ck_payload;

  assign restore     = br_resolve_i && br_mispredict_i;
  assign release_ck  = br_resolve_i && !br_mispredict_i;
  assign iss_ready_o = !restore
                       && !(iss_dst_we_i && fl_empty)
                       && !(iss_branch_i && ck_full);
  assign fire        = iss_valid_i && iss_ready_o;
  assign alloc       = fire && iss_dst_we_i;
  assign take        = fire && iss_branch_i;
  assign dst_phys_o  = fl_head_phys;
  assign head_after  = fl_head_ptr + PTRW'(alloc);
  assign ck_payload  = {map_next, head_after};
  assign ck_map      = ck_oldest[CKW-1:PTRW];

  rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop_i(alloc), .push_i(cmt_valid_i), .push_phys_i(cmt_prev_phys_i),
    .restore_i(restore), .restore_head_i(ck_oldest[PTRW-1:0]),
    .head_phys_o(fl_head_phys), .head_ptr_o(fl_head_ptr), .empty_o(fl_empty)
  );

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a_i(iss_src_a_i), .rd_b_i(iss_src_b_i), .rd_d_i(iss_dst_i),
    .rd_a_o(src_a_phys_o), .rd_b_o(src_b_phys_o), .rd_d_o(prev_phys_o),
    .wr_en_i(alloc), .wr_idx_i(iss_dst_i), .wr_phys_i(fl_head_phys),
    .restore_i(restore), .restore_map_i(ck_map),
    .map_cur_o(map_cur), .map_next_o(map_next)
  );

  rn_ckpt_queue #(.NUM_CKPT(NUM_CKPT), .W(CKW)) u_ckpt (
    .clk(clk), .rst_n(rst_n),
    .take_i(take), .payload_i(ck_payload),
    .release_i(release_ck), .flush_i(restore),
    .oldest_o(ck_oldest), .full_o(ck_full)
  );

  assert_alloc_mapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (map_cur[$past(iss_dst_i)] == $past(fl_head_phys)));
  assert_release_keeps_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_ck && !alloc) |=> $stable(map_cur));
  assert_restore_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (map_cur == $past(ck_map)));
endmodule

// File: tb/reg_renamer_tb.sv
module reg_renamer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // we, dst, src_a, src_b, exp_a, exp_b, exp_dst, exp_prev
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 3'd3, 3'd3, 3'd1, 4'd3,  4'd1,  4'd8,  4'd3},
    {1'b1, 3'd3, 3'd3, 3'd2, 4'd8,  4'd2,  4'd9,  4'd8},
    {1'b1, 3'd0, 3'd3, 3'd7, 4'd9,  4'd7,  4'd10, 4'd0},
    {1'b0, 3'd5, 3'd0, 3'd3, 4'd10, 4'd9,  4'd0,  4'd0},
    {1'b1, 3'd7, 3'd7, 3'd0, 4'd7,  4'd10, 4'd11, 4'd7}
  };

  logic clk = 0, rst_n = 0;
  logic iss_valid, iss_we, iss_br, cmt_valid, br_res, br_mis;
  logic [2:0] iss_dst, iss_sa, iss_sb;
  logic [3:0] cmt_prev;
  logic iss_ready;
  logic [3:0] pa, pb, pd, pp;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_renamer u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid_i(iss_valid), .iss_dst_we_i(iss_we), .iss_branch_i(iss_br),
    .iss_dst_i(iss_dst), .iss_src_a_i(iss_sa), .iss_src_b_i(iss_sb),
    .iss_ready_o(iss_ready), .src_a_phys_o(pa), .src_b_phys_o(pb),
    .dst_phys_o(pd), .prev_phys_o(pp),
    .cmt_valid_i(cmt_valid), .cmt_prev_phys_i(cmt_prev),
    .br_resolve_i(br_res), .br_mispredict_i(br_mis)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    iss_valid = 0; iss_we = 0; iss_br = 0; iss_dst = 0; iss_sa = 0; iss_sb = 0;
    cmt_valid = 0; cmt_prev = 0; br_res = 0; br_mis = 0;
  endtask

  // inputs change just after a rising edge; outputs are read at the falling edge
  task automatic step();
    @(posedge clk); #1; clear_in();
  endtask

  task automatic put(input logic we, input logic br, input int d, input int a, input int b);
    iss_valid = 1; iss_we = we; iss_br = br;
    iss_dst = 3'(d); iss_sa = 3'(a); iss_sb = 3'(b);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_in();
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset map and first free register
    put(1, 0, 6, 4, 6);
    chk("R1 ready", iss_ready, 1);
    chk("R1 map4", pa, 4);
    chk("R1 map6", pb, 6);
    chk("R1 first free", pd, 8);
    iss_valid = 0;
    step();

    // R2 / R3: vector walk
    for (int i = 0; i < NV; i++) begin
      put(VEC[i][25], 0, VEC[i][24:22], VEC[i][21:19], VEC[i][18:16]);
      chk("R2 src_a", pa, VEC[i][15:12]);
      chk("R2 src_b", pb, VEC[i][11:8]);
      if (VEC[i][25]) begin
        chk("R3 dst", pd, VEC[i][7:4]);
        chk("R3 prev", pp, VEC[i][3:0]);
      end
      step();
    end

    // R5: commit returns phys 3 to the tail (list now 12,13,14,15,3)
    cmt_valid = 1; cmt_prev = 4'd3;
    step();

    // R6: branch snapshot, then speculative allocations
    put(0, 1, 0, 3, 0);
    chk("R6 branch ready", iss_ready, 1);
    chk("R2 src before branch", pa, 9);
    step();
    put(1, 0, 3, 0, 0);
    chk("R3 spec dst", pd, 12);
    chk("R3 spec prev", pp, 9);
    step();
    put(1, 0, 1, 3, 0);
    chk("R3 spec src", pa, 12);
    chk("R3 spec dst2", pd, 13);
    step();

    // R7 + R9: mispredict with a concurrent commit of phys 0
    br_res = 1; br_mis = 1; cmt_valid = 1; cmt_prev = 4'd0;
    @(negedge clk);
    chk("R7 stall on recovery", iss_ready, 0);
    step();
    put(0, 0, 0, 3, 1);
    chk("R7 restored map3", pa, 9);
    chk("R7 restored map1", pb, 1);
    step();
    put(1, 0, 2, 0, 0);
    chk("R7 restored head", pd, 12);
    chk("R7 prev", pp, 2);
    step();

    // R6 stall on full snapshot queue, R8 release
    put(0, 1, 0, 0, 0); step();
    put(0, 1, 0, 0, 0); step();
    iss_valid = 1; iss_br = 1;
    @(negedge clk);
    chk("R6 full stall", iss_ready, 0);
    step();
    br_res = 1;
    step();
    put(0, 1, 0, 2, 4);
    chk("R8 ready after release", iss_ready, 1);
    chk("R8 map2 kept", pa, 12);
    step();
    br_res = 1; step();
    br_res = 1; step();

    // R4 / R5 / R9: drain free list; order 13,14,15,3,0
    begin
      int exp_d [5] = '{13, 14, 15, 3, 0};
      int exp_p [5] = '{4, 13, 14, 15, 3};
      for (int k = 0; k < 5; k++) begin
        put(1, 0, 4, 0, 0);
        chk("R5 reuse order", pd, exp_d[k]);
        chk("R3 prev chain", pp, exp_p[k]);
        step();
      end
    end
    put(1, 0, 4, 0, 0);
    chk("R4 empty stall", iss_ready, 0);
    iss_we = 0;
    @(negedge clk);
    chk("R4 non-writer ok", iss_ready, 1);
    step();
    cmt_valid = 1; cmt_prev = 4'd4;
    step();
    put(1, 0, 4, 4, 0);
    chk("R5 ready after commit", iss_ready, 1);
    chk("R5 recycled", pd, 4);
    chk("R2 same reg src", pa, 0);
    step();

    // R1: reset again
    rst_n = 0;
    step();
    #1 rst_n = 1;
    put(1, 0, 2, 5, 2);
    chk("R1 map5 after reset", pa, 5);
    chk("R1 map2 after reset", pb, 2);
    chk("R1 alloc after reset", pd, 8);
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule